// File: doc/BRIEF.md
# Bounds-Tightening Update Consolidator

This block is the one gate through which every change to a store of finite-domain variables must pass. The store keeps an inclusive interval (lower and upper bound) for each variable in on-chip RAM. Several nodes send update proposals, each naming a variable and a proposed interval. The unit serves one proposal per cycle and compares each bound with the stored one on its own terms. It writes back only the parts that shrink the interval and drops the rest.

The unit only ever narrows an interval, so the end state does not depend on the order in which proposals arrive. Nodes need no locking or sequencing among themselves. Whenever a bound actually changes, the unit sends a notify carrying the variable and its new interval to the node that owns the variable, so that cached copies stay coherent. A static owner map on an input port gives the owner of each variable. If a committed interval ends up empty (lower above upper), a conflict pulse reports the variable.

Each proposal goes through three steps: arbitration and capture, a synchronous RAM read, then compare and write. The read path forwards the value being written in the same cycle, so proposals back to back on one variable build on each other.

Top module: `bound_consolidator`

## Requirements
- R1: After reset every variable holds the full domain, lower bound 0 and upper bound all ones, and neither notify_valid nor conflict_valid is asserted.
- R2: A proposed lower bound is committed only if it is strictly greater than the stored lower bound; otherwise the stored lower bound is kept.
- R3: A proposed upper bound is committed only if it is strictly smaller than the stored upper bound; otherwise the stored upper bound is kept.
- R4: The two bounds are judged independently, so one proposal may commit its lower bound and reject its upper bound, or the reverse.
- R5: When at least one bound changes, notify_valid is high for one cycle, two clock edges after the edge at which the request was granted. notify_var, notify_lo and notify_hi give the variable and its full committed interval. notify_node equals owner_map[var*NODE_W +: NODE_W].
- R6: A proposal that changes neither bound, including one equal to the stored interval, produces no notify and leaves the stored interval unchanged.
- R7: When the committed lower bound exceeds the committed upper bound, conflict_valid pulses in the same cycle as the notify, with conflict_var set to the variable. An interval with lower equal to upper is not a conflict.
- R8: req_grant is one-hot among asserted req_valid bits and never zero while any request is pending. Grants rotate round-robin, starting from the port after the one granted most recently. A requester holds its request until it is granted.
- R9: Two proposals for the same variable granted in consecutive cycles are applied in sequence: the second is compared against the interval committed by the first.
- R10: Applying the same set of proposals to a variable in different orders leaves the same final interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | N_REQ | Per-port update request |
| req_var | input | N_REQ*VAR_W | Per-port variable index, port p at [p*VAR_W +: VAR_W] |
| req_lo | input | N_REQ*VAL_W | Per-port proposed lower bound |
| req_hi | input | N_REQ*VAL_W | Per-port proposed upper bound |
| owner_map | input | N_VAR*NODE_W | Static owner node of each variable |
| req_grant | output | N_REQ | One-hot grant, combinational from req_valid |
| notify_valid | output | 1 | Owner notify strobe |
| notify_node | output | NODE_W | Owner node of the updated variable |
| notify_var | output | VAR_W | Updated variable index |
| notify_lo | output | VAL_W | Committed lower bound |
| notify_hi | output | VAL_W | Committed upper bound |
| conflict_valid | output | 1 | Empty-domain pulse |
| conflict_var | output | VAR_W | Variable whose domain became empty |

## Verification
The compare logic gets proposals that are strictly tighter, strictly looser, exactly equal, and tighter on one side only. These separate a strict compare from a non-strict one and independent bounds from an all-or-nothing commit. Intervals that collapse to a single point are set against intervals that cross, to tell an empty domain from a singleton. Simultaneous requests on all ports show the rotation of the arbiter. Two same-variable proposals granted in consecutive cycles expose a read path that misses the write still in flight. Two opposite orderings of one proposal pair confirm that the final interval does not depend on order.

// File: rtl/bc_pkg.sv
package bc_pkg;
    localparam int unsigned BC_N_REQ  = 4;
    localparam int unsigned BC_N_VAR  = 16;
    localparam int unsigned BC_VAL_W  = 8;
    localparam int unsigned BC_N_NODE = 4;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/bc_rr_arbiter.sv
module bc_rr_arbiter #(
    parameter int unsigned N     = 4,
    localparam int unsigned IDX_W = bc_pkg::idx_width(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             gnt_any
);
    typedef struct packed {
        logic [IDX_W-1:0] last;
    } arb_t;

    arb_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int k = 1; k <= int'(N); k++) begin
            int c;
            c = (int'(st_q.last) + k) % int'(N);
            if (!gnt_any && req[c]) begin
                gnt_any = 1'b1;
                gnt[c]  = 1'b1;
                gnt_idx = IDX_W'(c);
            end
        end
        if (gnt_any) st_d.last = gnt_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.last <= IDX_W'(N - 1);
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bc_bound_store.sv
module bc_bound_store #(
    parameter int unsigned N_VAR = 16,
    parameter int unsigned VAL_W = 8,
    localparam int unsigned VAR_W = bc_pkg::idx_width(N_VAR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VAR_W-1:0] rd_addr,
    output logic [VAL_W-1:0] rd_lo,
    output logic [VAL_W-1:0] rd_hi,
    input  logic             wr_en,
    input  logic [VAR_W-1:0] wr_addr,
    input  logic [VAL_W-1:0] wr_lo,
    input  logic [VAL_W-1:0] wr_hi
);
    logic [VAL_W-1:0] lo_mem [N_VAR];
    logic [VAL_W-1:0] hi_mem [N_VAR];
    logic [VAL_W-1:0] rd_lo_d, rd_hi_d;

    // Read data bypasses the write landing at the same edge.
    always_comb begin
        rd_lo_d = lo_mem[rd_addr];
        rd_hi_d = hi_mem[rd_addr];
        if (wr_en && wr_addr == rd_addr) begin
            rd_lo_d = wr_lo;
            rd_hi_d = wr_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int v = 0; v < int'(N_VAR); v++) begin
                lo_mem[v] <= '0;
                hi_mem[v] <= '1;
            end
            rd_lo <= '0;
            rd_hi <= '1;
        end else begin
            if (wr_en) begin
                lo_mem[wr_addr] <= wr_lo;
                hi_mem[wr_addr] <= wr_hi;
            end
            rd_lo <= rd_lo_d;
            rd_hi <= rd_hi_d;
        end
    end
endmodule

// File: rtl/bc_tighten.sv
module bc_tighten #(
    parameter int unsigned VAL_W = 8
) (
    input  logic [VAL_W-1:0] cur_lo,
    input  logic [VAL_W-1:0] cur_hi,
    input  logic [VAL_W-1:0] prop_lo,
    input  logic [VAL_W-1:0] prop_hi,
    output logic [VAL_W-1:0] new_lo,
    output logic [VAL_W-1:0] new_hi,
    output logic             changed,
    output logic             empty
);
    logic lo_up, hi_dn;

    always_comb begin
        lo_up   = prop_lo > cur_lo;
        hi_dn   = prop_hi < cur_hi;
        new_lo  = lo_up ? prop_lo : cur_lo;
        new_hi  = hi_dn ? prop_hi : cur_hi;
        changed = lo_up | hi_dn;
        empty   = new_lo > new_hi;
    end
endmodule

// File: rtl/bound_consolidator.sv
module bound_consolidator #(
    parameter int unsigned N_REQ  = bc_pkg::BC_N_REQ,
    parameter int unsigned N_VAR  = bc_pkg::BC_N_VAR,
    parameter int unsigned VAL_W  = bc_pkg::BC_VAL_W,
    parameter int unsigned N_NODE = bc_pkg::BC_N_NODE,
    localparam int unsigned VAR_W  = bc_pkg::idx_width(N_VAR),
    localparam int unsigned NODE_W = bc_pkg::idx_width(N_NODE),
    localparam int unsigned REQ_W  = bc_pkg::idx_width(N_REQ)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_REQ-1:0]          req_valid,
    input  logic [N_REQ*VAR_W-1:0]    req_var,
    input  logic [N_REQ*VAL_W-1:0]    req_lo,
    input  logic [N_REQ*VAL_W-1:0]    req_hi,
    input  logic [N_VAR*NODE_W-1:0]   owner_map,
    output logic [N_REQ-1:0]          req_grant,
    output logic                      notify_valid,
    output logic [NODE_W-1:0]         notify_node,
    output logic [VAR_W-1:0]          notify_var,
    output logic [VAL_W-1:0]          notify_lo,
    output logic [VAL_W-1:0]          notify_hi,
    output logic                      conflict_valid,
    output logic [VAR_W-1:0]          conflict_var
);
    typedef struct packed {
        logic             s1_vld;
        logic [VAR_W-1:0] s1_var;
        logic [VAL_W-1:0] s1_lo;
        logic [VAL_W-1:0] s1_hi;
        logic             s2_vld;
        logic [VAR_W-1:0] s2_var;
        logic [VAL_W-1:0] s2_lo;
        logic [VAL_W-1:0] s2_hi;
        logic             n_vld;
        logic [NODE_W-1:0] n_node;
        logic [VAR_W-1:0] n_var;
        logic [VAL_W-1:0] n_lo;
        logic [VAL_W-1:0] n_hi;
        logic             c_vld;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [REQ_W-1:0] gnt_idx;
    logic             gnt_any;
    logic [VAL_W-1:0] cur_lo, cur_hi, new_lo, new_hi;
    logic             changed, empty, wr_en;

    bc_rr_arbiter #(.N(N_REQ)) i_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_valid),
        .gnt     (req_grant),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    bc_bound_store #(.N_VAR(N_VAR), .VAL_W(VAL_W)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (st_q.s1_var),
        .rd_lo   (cur_lo),
        .rd_hi   (cur_hi),
        .wr_en   (wr_en),
        .wr_addr (st_q.s2_var),
        .wr_lo   (new_lo),
        .wr_hi   (new_hi)
    );

    bc_tighten #(.VAL_W(VAL_W)) i_tighten (
        .cur_lo  (cur_lo),
        .cur_hi  (cur_hi),
        .prop_lo (st_q.s2_lo),
        .prop_hi (st_q.s2_hi),
        .new_lo  (new_lo),
        .new_hi  (new_hi),
        .changed (changed),
        .empty   (empty)
    );

    assign wr_en = st_q.s2_vld && changed;

    always_comb begin
        st_d = st_q;
        // stage 1: capture the granted proposal
        st_d.s1_vld = gnt_any;
        st_d.s1_var = req_var[gnt_idx*VAR_W +: VAR_W];
        st_d.s1_lo  = req_lo[gnt_idx*VAL_W +: VAL_W];
        st_d.s1_hi  = req_hi[gnt_idx*VAL_W +: VAL_W];
        // stage 2: proposal waits for the store read
        st_d.s2_vld = st_q.s1_vld;
        st_d.s2_var = st_q.s1_var;
        st_d.s2_lo  = st_q.s1_lo;
        st_d.s2_hi  = st_q.s1_hi;
        // stage 3: registered notify and conflict
        st_d.n_vld  = wr_en;
        st_d.c_vld  = wr_en && empty;
        if (wr_en) begin
            st_d.n_var  = st_q.s2_var;
            st_d.n_lo   = new_lo;
            st_d.n_hi   = new_hi;
            st_d.n_node = owner_map[st_q.s2_var*NODE_W +: NODE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign notify_valid   = st_q.n_vld;
    assign notify_node    = st_q.n_node;
    assign notify_var     = st_q.n_var;
    assign notify_lo      = st_q.n_lo;
    assign notify_hi      = st_q.n_hi;
    assign conflict_valid = st_q.c_vld;
    assign conflict_var   = st_q.n_var;
endmodule

// File: rtl/bound_consolidator_chk.sv
module bound_consolidator_chk #(
    parameter int unsigned N_REQ  = 4,
    parameter int unsigned N_VAR  = 16,
    parameter int unsigned VAL_W  = 8,
    parameter int unsigned VAR_W  = 4,
    parameter int unsigned NODE_W = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_REQ-1:0]        req_valid,
    input logic [N_REQ-1:0]        req_grant,
    input logic [N_VAR*NODE_W-1:0] owner_map,
    input logic                    notify_valid,
    input logic [NODE_W-1:0]       notify_node,
    input logic [VAR_W-1:0]        notify_var,
    input logic [VAL_W-1:0]        notify_lo,
    input logic [VAL_W-1:0]        notify_hi,
    input logic                    conflict_valid,
    input logic [VAR_W-1:0]        conflict_var
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!notify_valid && !conflict_valid));

    assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_grant));

    assert_grant_only_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant & ~req_valid) == '0);

    assert_grant_no_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_valid) |-> (|req_grant));

    assert_conflict_with_notify_R7: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_valid |-> (notify_valid && conflict_var == notify_var && notify_lo > notify_hi));

    assert_owner_lookup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |-> notify_node == owner_map[notify_var*NODE_W +: NODE_W]);
endmodule

bind bound_consolidator bound_consolidator_chk #(
    .N_REQ(N_REQ), .N_VAR(N_VAR), .VAL_W(VAL_W), .VAR_W(VAR_W), .NODE_W(NODE_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_grant(req_grant),
    .owner_map(owner_map), .notify_valid(notify_valid), .notify_node(notify_node),
    .notify_var(notify_var), .notify_lo(notify_lo), .notify_hi(notify_hi),
    .conflict_valid(conflict_valid), .conflict_var(conflict_var)
);

// File: tb/test_bound_consolidator.sv
module test_bound_consolidator;
    localparam int NR = 4, NV = 16, VW = 8, VARW = 4, NW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NR-1:0]      req_valid = '0;
    logic [NR*VARW-1:0] req_var = '0;
    logic [NR*VW-1:0]   req_lo = '0;
    logic [NR*VW-1:0]   req_hi = '0;
    logic [NV*NW-1:0]   owner_map;
    logic [NR-1:0]      req_grant;
    logic               notify_valid, conflict_valid;
    logic [NW-1:0]      notify_node;
    logic [VARW-1:0]    notify_var, conflict_var;
    logic [VW-1:0]      notify_lo, notify_hi;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bound_consolidator i_bound_consolidator (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_var(req_var),
        .req_lo(req_lo), .req_hi(req_hi), .owner_map(owner_map), .req_grant(req_grant),
        .notify_valid(notify_valid), .notify_node(notify_node), .notify_var(notify_var),
        .notify_lo(notify_lo), .notify_hi(notify_hi),
        .conflict_valid(conflict_valid), .conflict_var(conflict_var)
    );

    // {port[39:38], var[37:34], lo[33:26], hi[25:18], exp_notify[17], exp_lo[16:9], exp_hi[8:1], exp_conf[0]}
    localparam int NVEC = 9;
    localparam logic [39:0] VEC [0:NVEC-1] = '{
        {2'd0, 4'd3,  8'd10,  8'd200, 1'b1, 8'd10,  8'd200, 1'b0}, // R2 R3 both tighten
        {2'd1, 4'd3,  8'd5,   8'd250, 1'b0, 8'd0,   8'd0,   1'b0}, // R6 both looser
        {2'd2, 4'd3,  8'd20,  8'd250, 1'b1, 8'd20,  8'd200, 1'b0}, // R4 lower only
        {2'd3, 4'd3,  8'd0,   8'd150, 1'b1, 8'd20,  8'd150, 1'b0}, // R4 upper only
        {2'd0, 4'd3,  8'd20,  8'd150, 1'b0, 8'd0,   8'd0,   1'b0}, // R6 equal, strict compare
        {2'd2, 4'd7,  8'd100, 8'd100, 1'b1, 8'd100, 8'd100, 1'b0}, // R7 singleton is not empty
        {2'd1, 4'd7,  8'd101, 8'd255, 1'b1, 8'd101, 8'd100, 1'b1}, // R7 crossing
        {2'd3, 4'd0,  8'd255, 8'd0,   1'b1, 8'd255, 8'd0,   1'b1}, // R7 extreme crossing
        {2'd1, 4'd15, 8'd1,   8'd254, 1'b1, 8'd1,   8'd254, 1'b0}  // R2 R3 last variable
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] owner_of(input int v);
        return 2'(3 - (v % 4));
    endfunction

    task automatic drive(input int p, input int v, input int lo, input int hi);
        req_valid[p]          = 1'b1;
        req_var[p*VARW +: VARW] = VARW'(v);
        req_lo[p*VW +: VW]    = VW'(lo);
        req_hi[p*VW +: VW]    = VW'(hi);
    endtask

    // One isolated request, checked at the notify cycle.
    task automatic do_upd(input string tag, input int p, input int v, input int lo, input int hi,
                          input bit en, input int elo, input int ehi, input bit ec);
        @(negedge clk);
        drive(p, v, lo, hi);
        @(posedge clk);
        @(negedge clk);
        req_valid[p] = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " notify_valid"}, 32'(notify_valid), 32'(en));
        chk({tag, " conflict_valid"}, 32'(conflict_valid), 32'(ec));
        if (en) begin
            chk({tag, " notify_var"}, 32'(notify_var), 32'(v));
            chk({tag, " notify_lo"}, 32'(notify_lo), 32'(elo));
            chk({tag, " notify_hi"}, 32'(notify_hi), 32'(ehi));
            chk({tag, " notify_node R5"}, 32'(notify_node), 32'(owner_of(v)));
        end
        if (ec) chk({tag, " conflict_var"}, 32'(conflict_var), 32'(v));
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        for (int v = 0; v < NV; v++) owner_map[v*NW +: NW] = owner_of(v);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs quiet, store at full domain
        chk("R1 notify after reset", 32'(notify_valid), 0);
        chk("R1 conflict after reset", 32'(conflict_valid), 0);
        chk("R1 grant idle", 32'(req_grant), 0);
        do_upd("R1 full domain probe", 0, 5, 0, 255, 0, 0, 0, 0);
        do_upd("R1 full domain upper kept", 0, 5, 1, 255, 1, 1, 255, 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [39:0] e;
            e = VEC[i];
            do_upd($sformatf("vec%0d R2/R3/R4/R6/R7", i), int'(e[39:38]), int'(e[37:34]),
                   int'(e[33:26]), int'(e[25:18]), e[17], int'(e[16:9]), int'(e[8:1]), e[0]);
        end

        // R6: rejected proposal left the store alone, shown by the next notify
        do_upd("R6 store kept", 2, 3, 21, 255, 1, 21, 150, 0);

        // R8: last grant was port 2, so rotation runs 3,0,1,2
        @(negedge clk);
        for (int p = 0; p < NR; p++) drive(p, 8 + p, p + 1, 255);
        for (int k = 0; k < NR; k++) begin
            int ep;
            ep = (3 + k) % NR;
            #1;
            chk($sformatf("R8 grant step %0d", k), 32'(req_grant), 32'(1 << ep));
            @(posedge clk);
            @(negedge clk);
            req_valid[ep] = 1'b0;
        end
        repeat (4) @(negedge clk);

        // R9: last grant port 2 -> port 0 first, then port 1, same variable
        drive(0, 12, 30, 200);
        drive(1, 12, 40, 210);
        @(posedge clk);
        @(negedge clk);
        req_valid[0] = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid[1] = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R9 first notify", 32'(notify_valid), 1);
        chk("R9 first lo", 32'(notify_lo), 30);
        chk("R9 first hi", 32'(notify_hi), 200);
        @(posedge clk);
        @(negedge clk);
        chk("R9 second notify", 32'(notify_valid), 1);
        chk("R9 second lo", 32'(notify_lo), 40);
        chk("R9 second hi uses forwarded value", 32'(notify_hi), 200);

        // R10: same pair of proposals in opposite orders
        do_upd("R10 var13 first A", 0, 13, 50, 180, 1, 50, 180, 0);
        do_upd("R10 var13 then B", 1, 13, 60, 190, 1, 60, 180, 0);
        do_upd("R10 var14 first B", 2, 14, 60, 190, 1, 60, 190, 0);
        do_upd("R10 var14 then A", 3, 14, 50, 180, 1, 60, 180, 0);

        done = 1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end
endmodule